// File: doc/BRIEF.md
# DMA Channel Address and Count Sequencer

This block steps one DMA channel through a single block transfer. A start pulse captures a source address, a destination address, an element count and, for each side, an element width code and an address mode. The block then offers one element at a time on a valid/ready interface. Every element carries the current source and destination addresses. After each accepted element both addresses move by their own step and the remaining count drops by one.

The count is kept in source-width elements. Each address advances by 2^width bytes in the direction its mode selects, or it stays fixed. A burst code groups the elements, and the block marks the last element of each group so that a downstream bus adapter can close its bursts. The channel ends in one of three ways: it reaches terminal count, it sees a bus error reported with an accepted element, or it honours an abort request at the next element boundary. Each outcome gives a one-cycle pulse.

Top module: `dma_walk_seq`

## Requirements
- R1: After reset the block is idle: busy, element valid and the three end pulses are all low.
- R2: A start pulse in idle with a nonzero count makes busy and element valid high in the next cycle, and the presented addresses equal the programmed source and destination addresses.
- R3: Each accepted element moves an address according to its own mode code: 0 adds the step, 1 subtracts the step, and 2 or 3 leave it unchanged. The step is 2^w bytes for width code w, and codes above 5 act as 5. While no element is accepted, both addresses hold.
- R4: A programmed count N produces exactly N accepted elements. In the cycle after the Nth is accepted, the terminal-count pulse is high for one cycle and busy and valid are low.
- R5: A start with a count of zero presents no element. The error pulse is high in the cycle after the start, and busy stays low.
- R6: An element accepted while the bus error input is high ends the transfer. The error pulse is high in the next cycle, with no terminal-count pulse, and busy and valid are low.
- R7: An abort request seen while busy drops element valid from the next cycle. One cycle later the abort pulse is high and busy is low. An element accepted on the same edge as the request still counts and moves the addresses.
- R8: With burst code b, where codes above 10 act as 10, the burst-last flag is high on element k (counting from 0) when (k+1) is a multiple of 2^b, and also on the final element.
- R9: A start pulse while busy is ignored: the presented addresses do not change.
- R10: An abort request while idle has no effect. No abort pulse follows.
- R11: If the element accepted on the same edge as an abort request is the final one, the transfer ends with terminal count and no abort pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; captures the configuration when idle |
| cfg_src_addr_i | input | ADDR_W | Source start address |
| cfg_dst_addr_i | input | ADDR_W | Destination start address |
| cfg_count_i | input | CNT_W | Element count in source-width units |
| cfg_src_width_i | input | 3 | Source width code (2^code bytes) |
| cfg_dst_width_i | input | 3 | Destination width code (2^code bytes) |
| cfg_burst_i | input | 4 | Burst code (2^code elements per group) |
| cfg_src_mode_i | input | 2 | Source address mode: 0 up, 1 down, 2/3 fixed |
| cfg_dst_mode_i | input | 2 | Destination address mode: 0 up, 1 down, 2/3 fixed |
| abort_i | input | 1 | Abort request |
| elem_valid_o | output | 1 | Element request valid |
| elem_src_addr_o | output | ADDR_W | Source address of the current element |
| elem_dst_addr_o | output | ADDR_W | Destination address of the current element |
| elem_burst_last_o | output | 1 | Current element closes a burst group |
| elem_ready_i | input | 1 | Element accepted by the bus side |
| elem_err_i | input | 1 | Bus error, qualified by an accepted element |
| busy_o | output | 1 | Channel is walking a transfer |
| tc_o | output | 1 | Terminal-count pulse |
| err_o | output | 1 | Error pulse (bus error or zero count) |
| abort_o | output | 1 | Abort-completed pulse |

## Verification
Every result lands a fixed number of edges after its cause. Addresses and valid change one edge after a start or an accepted element. The terminal-count and error pulses appear one edge after the deciding handshake or start. The abort pulse appears two edges after the request. The bench drives inputs one time unit after a rising edge and reads outputs only after the next edge plus that unit, so each check reads the cycle in which the result is due. It also checks the cycle after each pulse to confirm the pulse lasts a single cycle.

// File: rtl/dma_seq_pkg.sv
`timescale 1ns/1ps
package dma_seq_pkg;
   typedef enum logic [1:0] {
      AM_INC = 2'd0,
      AM_DEC = 2'd1,
      AM_FIX = 2'd2,
      AM_RSV = 2'd3
   } addr_mode_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } seq_state_e;
endpackage

// File: rtl/dma_seq_addr.sv
`timescale 1ns/1ps
module dma_seq_addr
   import dma_seq_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int MAX_WCODE = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [2:0]        load_wcode,
   input  logic [1:0]        load_mode,
   input  logic              advance,
   output logic [ADDR_W-1:0] addr
);
   localparam logic [2:0] WCODE_CAP = 3'(MAX_WCODE);

   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] step;
   logic [ADDR_W-1:0] addr_nxt;
   logic [2:0]        wc_q;
   addr_mode_e        mode_q;

   always_comb step = ADDR_W'(1) << wc_q;

   always_comb begin
      case (mode_q)
         AM_INC:  addr_nxt = addr_q + step;
         AM_DEC:  addr_nxt = addr_q - step;
         default: addr_nxt = addr_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         wc_q   <= '0;
         mode_q <= AM_INC;
      end else if (load) begin
         addr_q <= load_addr;
         wc_q   <= (load_wcode > WCODE_CAP) ? WCODE_CAP : load_wcode;
         mode_q <= addr_mode_e'(load_mode);
      end else if (advance) begin
         addr_q <= addr_nxt;
      end
   end

   assign addr = addr_q;

   assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !advance) |=> $stable(addr_q));
   assert_fixed_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load && (mode_q == AM_FIX || mode_q == AM_RSV)) |=> $stable(addr_q));
   assert_moving_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load && (mode_q == AM_INC || mode_q == AM_DEC)) |=> !$stable(addr_q));
endmodule

// File: rtl/dma_seq_count.sv
`timescale 1ns/1ps
module dma_seq_count #(
   parameter int CNT_W     = 22,
   parameter int MAX_BCODE = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_cnt,
   input  logic [3:0]       load_bcode,
   input  logic             advance,
   output logic             remain_one,
   output logic             burst_last
);
   logic [CNT_W-1:0] remain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       remain_q <= '0;
      else if (load)    remain_q <= load_cnt;
      else if (advance) remain_q <= remain_q - CNT_W'(1);
   end

   assign remain_one = (remain_q == CNT_W'(1));

   generate
      if (MAX_BCODE == 0) begin : g_single
         assign burst_last = 1'b1;
      end else begin : g_group
         localparam int         BEAT_W = MAX_BCODE;
         localparam logic [3:0] BCAP   = 4'(MAX_BCODE);
         logic [BEAT_W-1:0] beat_q;
         logic [BEAT_W-1:0] mask;
         logic [3:0]        bc_q;
         logic              group_end;

         assign mask      = (BEAT_W'(1) << bc_q) - BEAT_W'(1);
         assign group_end = (beat_q == mask);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               beat_q <= '0;
               bc_q   <= '0;
            end else if (load) begin
               beat_q <= '0;
               bc_q   <= (load_bcode > BCAP) ? BCAP : load_bcode;
            end else if (advance) begin
               beat_q <= group_end ? '0 : beat_q + BEAT_W'(1);
            end
         end

         assign burst_last = group_end || remain_one;
      end
   endgenerate

   assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      advance |-> (remain_q != '0));
   assert_nonzero_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (load_cnt != '0));
endmodule

// File: rtl/dma_seq_ctrl.sv
`timescale 1ns/1ps
module dma_seq_ctrl
   import dma_seq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic cnt_zero,
   input  logic abort_req,
   input  logic elem_ready,
   input  logic elem_err,
   input  logic remain_one,
   output logic load,
   output logic advance,
   output logic elem_valid,
   output logic busy,
   output logic tc_pulse,
   output logic err_pulse,
   output logic abort_pulse
);
   seq_state_e state_q;
   logic       abort_q;
   logic       hs;

   assign busy       = (state_q == ST_RUN);
   assign elem_valid = busy && !abort_q;
   assign hs         = elem_valid && elem_ready;
   assign advance    = hs && !elem_err;
   assign load       = !busy && start && !cnt_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         abort_q     <= 1'b0;
         tc_pulse    <= 1'b0;
         err_pulse   <= 1'b0;
         abort_pulse <= 1'b0;
      end else begin
         tc_pulse    <= 1'b0;
         err_pulse   <= 1'b0;
         abort_pulse <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               abort_q <= 1'b0;
               if (start) begin
                  if (cnt_zero) err_pulse <= 1'b1;
                  else          state_q   <= ST_RUN;
               end
            end
            default: begin
               if (hs) begin
                  if (elem_err) begin
                     state_q   <= ST_IDLE;
                     err_pulse <= 1'b1;
                     abort_q   <= 1'b0;
                  end else if (remain_one) begin
                     state_q  <= ST_IDLE;
                     tc_pulse <= 1'b1;
                     abort_q  <= 1'b0;
                  end else if (abort_req) begin
                     abort_q <= 1'b1;
                  end
               end else if (abort_q) begin
                  state_q     <= ST_IDLE;
                  abort_pulse <= 1'b1;
                  abort_q     <= 1'b0;
               end else if (abort_req) begin
                  abort_q <= 1'b1;
               end
            end
         endcase
      end
   end

   assert_single_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tc_pulse, err_pulse, abort_pulse}));
   assert_tc_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tc_pulse |-> $past(hs && remain_one && !elem_err));
   assert_zero_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && cnt_zero) |=> (err_pulse && !busy));
   assert_abort_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && abort_q) |=> (abort_pulse && !busy));
   assert_idle_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> !abort_pulse && !busy);
endmodule

// File: rtl/dma_walk_seq.sv
`timescale 1ns/1ps
module dma_walk_seq
   import dma_seq_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int CNT_W     = 22,
   parameter int MAX_WCODE = 5,
   parameter int MAX_BCODE = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] cfg_src_addr_i,
   input  logic [ADDR_W-1:0] cfg_dst_addr_i,
   input  logic [CNT_W-1:0]  cfg_count_i,
   input  logic [2:0]        cfg_src_width_i,
   input  logic [2:0]        cfg_dst_width_i,
   input  logic [3:0]        cfg_burst_i,
   input  logic [1:0]        cfg_src_mode_i,
   input  logic [1:0]        cfg_dst_mode_i,
   input  logic              abort_i,
   output logic              elem_valid_o,
   output logic [ADDR_W-1:0] elem_src_addr_o,
   output logic [ADDR_W-1:0] elem_dst_addr_o,
   output logic              elem_burst_last_o,
   input  logic              elem_ready_i,
   input  logic              elem_err_i,
   output logic              busy_o,
   output logic              tc_o,
   output logic              err_o,
   output logic              abort_o
);
   generate
      if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_addr_w
         $error("ADDR_W must lie in 8..64");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt_w
         $error("CNT_W must lie in 1..32");
      end
      if (MAX_WCODE < 0 || MAX_WCODE > 7 || (1 << MAX_WCODE) >= ADDR_W * 8) begin : g_bad_wcode
         $error("MAX_WCODE out of range for a 3-bit code or the address width");
      end
      if (MAX_BCODE < 0 || MAX_BCODE > 15) begin : g_bad_bcode
         $error("MAX_BCODE must fit the 4-bit burst code");
      end
   endgenerate

   logic load, advance, remain_one;

   dma_seq_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start_i),
      .cnt_zero    (cfg_count_i == '0),
      .abort_req   (abort_i),
      .elem_ready  (elem_ready_i),
      .elem_err    (elem_err_i),
      .remain_one  (remain_one),
      .load        (load),
      .advance     (advance),
      .elem_valid  (elem_valid_o),
      .busy        (busy_o),
      .tc_pulse    (tc_o),
      .err_pulse   (err_o),
      .abort_pulse (abort_o)
   );

   dma_seq_count #(.CNT_W(CNT_W), .MAX_BCODE(MAX_BCODE)) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .load_cnt   (cfg_count_i),
      .load_bcode (cfg_burst_i),
      .advance    (advance),
      .remain_one (remain_one),
      .burst_last (elem_burst_last_o)
   );

   dma_seq_addr #(.ADDR_W(ADDR_W), .MAX_WCODE(MAX_WCODE)) u_src (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .load_addr  (cfg_src_addr_i),
      .load_wcode (cfg_src_width_i),
      .load_mode  (cfg_src_mode_i),
      .advance    (advance),
      .addr       (elem_src_addr_o)
   );

   dma_seq_addr #(.ADDR_W(ADDR_W), .MAX_WCODE(MAX_WCODE)) u_dst (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .load_addr  (cfg_dst_addr_i),
      .load_wcode (cfg_dst_width_i),
      .load_mode  (cfg_dst_mode_i),
      .advance    (advance),
      .addr       (elem_dst_addr_o)
   );

   assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !advance) |=> ($stable(elem_src_addr_o) && $stable(elem_dst_addr_o)));
   assert_valid_only_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      elem_valid_o |-> busy_o);
endmodule

// File: tb/dma_walk_seq_tb.sv
`timescale 1ns/1ps
module dma_walk_seq_tb;
   typedef struct packed {
      logic [31:0] src;
      logic [31:0] dst;
      logic [21:0] cnt;
      logic [2:0]  sw;
      logic [2:0]  dw;
      logic [1:0]  sm;
      logic [1:0]  dm;
      logic [3:0]  bc;
   } vec_t;

   localparam int NVEC = 6;
   localparam vec_t VECS [NVEC] = '{
      '{32'h0000_1000, 32'h0000_2000, 22'd5, 3'd2, 3'd2, 2'd0, 2'd0, 4'd1},
      '{32'h0000_8000, 32'h0000_0400, 22'd7, 3'd0, 3'd1, 2'd1, 2'd0, 4'd2},
      '{32'h0000_3000, 32'h0000_3100, 22'd4, 3'd5, 3'd3, 2'd2, 2'd1, 4'd0},
      '{32'h0000_0100, 32'h0000_0200, 22'd9, 3'd7, 3'd6, 2'd3, 2'd0, 4'd3},
      '{32'h0000_0040, 32'h0000_FFF0, 22'd3, 3'd1, 3'd4, 2'd0, 2'd1, 4'd15},
      '{32'h0000_0010, 32'h0000_0020, 22'd1, 3'd3, 3'd3, 2'd0, 2'd1, 4'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] c_src = '0, c_dst = '0;
   logic [21:0] c_cnt = '0;
   logic [2:0]  c_sw = '0, c_dw = '0;
   logic [1:0]  c_sm = '0, c_dm = '0;
   logic [3:0]  c_bc = '0;
   logic        abort = 1'b0, ready = 1'b0, berr = 1'b0;
   logic        valid, blast, busy, tc, err, abt;
   logic [31:0] src_a, dst_a;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   dma_walk_seq u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start),
      .cfg_src_addr_i(c_src), .cfg_dst_addr_i(c_dst), .cfg_count_i(c_cnt),
      .cfg_src_width_i(c_sw), .cfg_dst_width_i(c_dw), .cfg_burst_i(c_bc),
      .cfg_src_mode_i(c_sm), .cfg_dst_mode_i(c_dm), .abort_i(abort),
      .elem_valid_o(valid), .elem_src_addr_o(src_a), .elem_dst_addr_o(dst_a),
      .elem_burst_last_o(blast), .elem_ready_i(ready), .elem_err_i(berr),
      .busy_o(busy), .tc_o(tc), .err_o(err), .abort_o(abt)
   );

   task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", what, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   function automatic logic [31:0] nxt(logic [31:0] a, logic [1:0] m, logic [2:0] w);
      logic [31:0] st;
      st = 32'(1) << ((w > 3'd5) ? 3'd5 : w);
      case (m)
         2'd0:    return a + st;
         2'd1:    return a - st;
         default: return a;
      endcase
   endfunction

   task automatic launch(input vec_t t);
      c_src = t.src; c_dst = t.dst; c_cnt = t.cnt;
      c_sw = t.sw; c_dw = t.dw; c_sm = t.sm; c_dm = t.dm; c_bc = t.bc;
      start = 1'b1;
      tick;
      start = 1'b0;
   endtask

   task automatic run_vec(input vec_t t);
      logic [31:0] es, ed;
      int blen;
      es = t.src; ed = t.dst;
      blen = 1 << ((t.bc > 4'd10) ? 10 : int'(t.bc));
      launch(t);
      chk("R2 busy after start", 64'(busy), 64'd1);
      ready = 1'b1;
      for (int k = 0; k < int'(t.cnt); k++) begin
         chk("R2 valid", 64'(valid), 64'd1);
         chk("R3 src addr", 64'(src_a), 64'(es));
         chk("R3 dst addr", 64'(dst_a), 64'(ed));
         chk("R8 burst last", 64'(blast),
             64'(((k + 1) % blen == 0) || (k == int'(t.cnt) - 1)));
         chk("R4 no early tc", 64'(tc), 64'd0);
         tick;
         es = nxt(es, t.sm, t.sw);
         ed = nxt(ed, t.dm, t.dw);
      end
      ready = 1'b0;
      chk("R4 tc pulse", 64'(tc), 64'd1);
      chk("R4 busy low", 64'(busy), 64'd0);
      chk("R4 valid low", 64'(valid), 64'd0);
      tick;
      chk("R4 tc single cycle", 64'(tc), 64'd0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         bad++;
         total++;
         $display("FAIL watchdog act=%0d exp=<50000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      vec_t t;
      repeat (3) tick;
      chk("R1 busy", 64'(busy), 64'd0);
      chk("R1 valid", 64'(valid), 64'd0);
      chk("R1 pulses", 64'({tc, err, abt}), 64'd0);
      rst_n = 1'b1;
      tick;
      chk("R1 idle after release", 64'({busy, valid, tc, err, abt}), 64'd0);

      for (int v = 0; v < NVEC; v++) begin
         run_vec(VECS[v]);
      end

      // R3 stall hold, R9 start ignored, R7 abort without handshake
      t = '{32'h0000_5000, 32'h0000_6000, 22'd3, 3'd2, 3'd2, 2'd0, 2'd1, 4'd0};
      launch(t);
      tick; tick;
      chk("R3 hold while stalled src", 64'(src_a), 64'h5000);
      chk("R3 hold while stalled dst", 64'(dst_a), 64'h6000);
      c_src = 32'h0000_9000; c_dst = 32'h0000_A000; c_cnt = 22'd8;
      start = 1'b1;
      tick;
      start = 1'b0;
      chk("R9 start ignored src", 64'(src_a), 64'h5000);
      chk("R9 start ignored dst", 64'(dst_a), 64'h6000);
      ready = 1'b1;
      tick;
      ready = 1'b0;
      chk("R3 step after accept src", 64'(src_a), 64'h5004);
      chk("R3 step after accept dst", 64'(dst_a), 64'h5FFC);
      abort = 1'b1;
      tick;
      abort = 1'b0;
      chk("R7 valid drops", 64'(valid), 64'd0);
      chk("R7 still busy", 64'(busy), 64'd1);
      tick;
      chk("R7 abort pulse", 64'(abt), 64'd1);
      chk("R7 busy low", 64'(busy), 64'd0);
      chk("R7 no tc", 64'(tc), 64'd0);
      tick;
      chk("R7 abort single cycle", 64'(abt), 64'd0);

      // R10 abort while idle
      abort = 1'b1;
      tick;
      abort = 1'b0;
      chk("R10 no abort pulse", 64'(abt), 64'd0);
      tick;
      chk("R10 still no abort pulse", 64'(abt), 64'd0);
      chk("R10 idle", 64'(busy), 64'd0);

      // R7 abort on the same edge as a handshake
      t = '{32'h0000_0200, 32'h0000_0300, 22'd4, 3'd1, 3'd0, 2'd0, 2'd0, 4'd0};
      launch(t);
      ready = 1'b1; abort = 1'b1;
      tick;
      ready = 1'b0; abort = 1'b0;
      chk("R7 accepted element counts", 64'(src_a), 64'h0202);
      chk("R7 dst moved", 64'(dst_a), 64'h0301);
      chk("R7 valid low after abort", 64'(valid), 64'd0);
      tick;
      chk("R7 abort pulse after handshake", 64'(abt), 64'd1);
      chk("R7 no tc after handshake", 64'(tc), 64'd0);

      // R11 abort together with the final element
      t = '{32'h0000_0400, 32'h0000_0500, 22'd1, 3'd0, 3'd0, 2'd0, 2'd0, 4'd0};
      launch(t);
      ready = 1'b1; abort = 1'b1;
      tick;
      ready = 1'b0; abort = 1'b0;
      chk("R11 tc wins", 64'(tc), 64'd1);
      chk("R11 no abort", 64'(abt), 64'd0);
      chk("R11 busy low", 64'(busy), 64'd0);
      tick;
      chk("R11 no late abort", 64'(abt), 64'd0);

      // R6 bus error
      t = '{32'h0000_0800, 32'h0000_0900, 22'd5, 3'd2, 3'd2, 2'd0, 2'd0, 4'd0};
      launch(t);
      ready = 1'b1;
      tick;
      berr = 1'b1;
      tick;
      ready = 1'b0; berr = 1'b0;
      chk("R6 error pulse", 64'(err), 64'd1);
      chk("R6 no tc", 64'(tc), 64'd0);
      chk("R6 stopped", 64'({busy, valid}), 64'd0);
      tick;
      chk("R6 error single cycle", 64'(err), 64'd0);

      // R5 zero count
      t = '{32'h0000_0C00, 32'h0000_0D00, 22'd0, 3'd2, 3'd2, 2'd0, 2'd0, 4'd0};
      launch(t);
      chk("R5 error pulse", 64'(err), 64'd1);
      chk("R5 no busy", 64'(busy), 64'd0);
      chk("R5 no element", 64'(valid), 64'd0);
      tick;
      chk("R5 error single cycle", 64'(err), 64'd0);
      chk("R5 still no element", 64'(valid), 64'd0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule